// File: doc/BRIEF.md
# Compacting Instruction Fetch Buffer

This block is the queue between instruction fetch and decode. Each cycle the fetch stage may offer one packet of fixed-width 32-bit instruction slots. These slots have already been expanded from compressed form. Each slot carries its own valid bit, its program counter and a flag saying whether it started as a 16-bit instruction. Slots that are invalid or misaligned are squeezed out as the packet is written. The surviving instructions therefore sit in consecutive storage entries, in ascending slot order, which is program order.

On the read side the block presents up to a fixed number of instructions per cycle, oldest first. Each output lane has its own valid bit. The consumer takes every presented instruction in a cycle where it signals ready. When the queue is empty, an accepted packet is presented on the outputs in the same cycle. Any part of it that the consumer takes is never written into storage. A flush input discards all held instructions and the packet arriving in that cycle.

The queue is a circular store with separate head and tail pointers. Space is checked per packet: a packet is accepted only when there is room for a completely full one.

Top module: `instPackQueue`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, the queue is empty: `enqReady` is 1 and every bit of `deqValid` is 0.
- R2: `enqReady` is 1 exactly when the number of free entries is at least FETCH_WIDTH. The number of free entries is QUEUE_DEPTH minus the instructions held.
- R3: Of an accepted packet, only the slots whose bit in `enqMask` is 1 are kept. They are kept in ascending slot index, bit i of the mask belonging to slot i. They leave the queue with no gap between them and after every instruction accepted earlier.
- R4: Each delivered instruction carries the 32-bit word, the PC and the compressed-origin flag of its slot, all unchanged. Slot i occupies bits [32*i +: 32] of `enqInst`, bits [32*i +: 32] of `enqPc` and bit i of `enqRvc`. Output lane k uses the same layout.
- R5: Output lane k is valid exactly when k is less than the number presented. That number is the smaller of DEQ_WIDTH and the instructions held. Lane 0 always holds the oldest instruction, so `deqValid` is always filled from bit 0 upward.
- R6: In a cycle with `deqReady` high, all presented instructions are consumed. With `deqReady` low, none are consumed, and the presented instructions stay the same in the next cycle.
- R7: When the queue is empty and a packet is accepted, its first surviving instructions appear on the outputs in that same cycle. If `deqReady` is also high, those instructions are consumed and never stored. The rest of the packet is stored.
- R8: A packet offered while `enqReady` is 0 is ignored and changes nothing that is held.
- R9: In a cycle with `flush` high, `deqValid` is 0, the offered packet is dropped and all held instructions are discarded. The queue is empty in the next cycle.
- R10: An accepted packet whose mask is all zero stores nothing and presents nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flush | input | 1 | Discard all held and arriving instructions |
| enqValid | input | 1 | A fetch packet is offered |
| enqReady | output | 1 | Room for a full packet |
| enqMask | input | FETCH_WIDTH | Per-slot valid bits |
| enqInst | input | 32*FETCH_WIDTH | Expanded instruction words |
| enqPc | input | 32*FETCH_WIDTH | Per-slot program counters |
| enqRvc | input | FETCH_WIDTH | Per-slot compressed-origin flags |
| deqReady | input | 1 | Consumer takes all presented lanes |
| deqValid | output | DEQ_WIDTH | Per-lane valid bits |
| deqInst | output | 32*DEQ_WIDTH | Presented instruction words |
| deqPc | output | 32*DEQ_WIDTH | Presented program counters |
| deqRvc | output | DEQ_WIDTH | Presented compressed-origin flags |

## Verification
The assertions assume four things about the inputs:
- Control inputs are never unknown after reset.
- The consumer takes every presented lane whenever it raises `deqReady`, never a subset.
- QUEUE_DEPTH is at least FETCH_WIDTH.
- DEQ_WIDTH is at most FETCH_WIDTH.

The stimulus drives every input half a cycle away from the sampling edge and holds it for the whole cycle. It keeps the default parameters, which meet both limits. It may offer packets while `enqReady` is low, since the block must ignore them, but it never relies on a partially consumed output group.

// File: rtl/fbufPkg.sv
package fbufPkg;
  localparam int INST_W = 32;
  localparam int PC_W   = 32;

  // One expanded instruction slot
  typedef struct packed {
    logic [INST_W-1:0] inst;
    logic [PC_W-1:0]   pc;
    logic              fromRvc;
  } fbufSlot_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic writeEn;   // some entries are written this cycle
    logic bypassEn;  // outputs are taken from the arriving packet
  } fbufStrobe_t;
endpackage

// File: rtl/fbufCompact.sv
module fbufCompact
  import fbufPkg::*;
#(
  parameter int FETCH_WIDTH = 4
) (
  input  logic [FETCH_WIDTH-1:0]            slotMask,
  input  fbufSlot_t [FETCH_WIDTH-1:0]       slotIn,
  output fbufSlot_t [FETCH_WIDTH-1:0]       packedOut,
  output logic [$clog2(FETCH_WIDTH+1)-1:0]  packedCnt
);
  localparam int CNT_W = $clog2(FETCH_WIDTH + 1);

  // Rank of each slot: number of valid slots below it
  logic [CNT_W-1:0] slotRank [FETCH_WIDTH];

  for (genvar i = 0; i < FETCH_WIDTH; i++) begin : g_rank
    if (i == 0) begin : g_first
      assign slotRank[i] = '0;
    end else begin : g_rest
      assign slotRank[i] = CNT_W'($countones(slotMask[i-1:0]));
    end
  end

  // Output position k takes the valid slot whose rank is k
  always_comb begin
    packedOut = '0;
    for (int k = 0; k < FETCH_WIDTH; k++) begin
      for (int i = 0; i < FETCH_WIDTH; i++) begin
        if (slotMask[i] && (slotRank[i] == CNT_W'(k))) begin
          packedOut[k] = slotIn[i];
        end
      end
    end
  end

  assign packedCnt = CNT_W'($countones(slotMask));
endmodule

// File: rtl/fbufCtrl.sv
module fbufCtrl
  import fbufPkg::*;
#(
  parameter int FETCH_WIDTH = 4,
  parameter int QUEUE_DEPTH = 16,
  parameter int DEQ_WIDTH   = 2
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                flush,
  input  logic                                enqValid,
  input  logic [$clog2(FETCH_WIDTH+1)-1:0]    enqCnt,
  input  logic                                deqReady,
  output logic                                enqReady,
  output logic [$clog2(QUEUE_DEPTH)-1:0]      headPtr,
  output logic [$clog2(QUEUE_DEPTH)-1:0]      tailPtr,
  output logic [$clog2(FETCH_WIDTH+1)-1:0]    wrSkip,
  output logic [$clog2(FETCH_WIDTH+1)-1:0]    wrCnt,
  output logic [$clog2(DEQ_WIDTH+1)-1:0]      outCnt,
  output fbufStrobe_t                         strobe
);
  localparam int PTR_W  = $clog2(QUEUE_DEPTH);
  localparam int CNT_W  = $clog2(QUEUE_DEPTH + 1);
  localparam int FCNT_W = $clog2(FETCH_WIDTH + 1);
  localparam int DCNT_W = $clog2(DEQ_WIDTH + 1);

  logic [PTR_W-1:0]  headQ, tailQ;
  logic [CNT_W-1:0]  countQ;
  logic              isEmpty, enqFire;
  logic [DCNT_W-1:0] takeCnt, popCnt;

  function automatic int minInt(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  function automatic logic [PTR_W-1:0] advance(input logic [PTR_W-1:0] ptr, input int n);
    int sum;
    sum = int'(ptr) + n;
    if (sum >= QUEUE_DEPTH) sum = sum - QUEUE_DEPTH;
    return PTR_W'(sum);
  endfunction

  always_comb begin
    isEmpty  = (countQ == '0);
    enqReady = (int'(countQ) + FETCH_WIDTH) <= QUEUE_DEPTH;
    enqFire  = enqValid && enqReady && !flush;

    if (flush)        outCnt = '0;
    else if (!isEmpty) outCnt = DCNT_W'(minInt(int'(countQ), DEQ_WIDTH));
    else if (enqFire) outCnt = DCNT_W'(minInt(int'(enqCnt), DEQ_WIDTH));
    else              outCnt = '0;

    takeCnt = deqReady ? outCnt : '0;
    popCnt  = isEmpty ? '0 : takeCnt;
    wrSkip  = isEmpty ? FCNT_W'(int'(takeCnt)) : '0;
    wrCnt   = enqFire ? FCNT_W'(int'(enqCnt) - int'(wrSkip)) : '0;

    strobe.writeEn  = (wrCnt != '0);
    strobe.bypassEn = isEmpty && enqFire;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      headQ  <= '0;
      tailQ  <= '0;
      countQ <= '0;
    end else begin
      headQ  <= advance(headQ, int'(popCnt));
      tailQ  <= advance(tailQ, int'(wrCnt));
      countQ <= CNT_W'(int'(countQ) + int'(wrCnt) - int'(popCnt));
    end
  end

  assign headPtr = headQ;
  assign tailPtr = tailQ;

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    enqReady |=> (int'(countQ) <= QUEUE_DEPTH));

  // R8
  ignored_enq_chk: assert property (@(posedge clk) disable iff (rst)
    (enqValid && !enqReady && !deqReady && !flush) |=> $stable(countQ) && $stable(tailPtr));

  // R9
  flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (countQ == '0) && (headPtr == tailPtr));

  // R7
  bypass_show_chk: assert property (@(posedge clk) disable iff (rst)
    (isEmpty && enqValid && enqReady && !flush && (enqCnt != '0)) |-> (outCnt != '0));
endmodule

// File: rtl/fbufData.sv
module fbufData
  import fbufPkg::*;
#(
  parameter int FETCH_WIDTH = 4,
  parameter int QUEUE_DEPTH = 16,
  parameter int DEQ_WIDTH   = 2
) (
  input  logic                              clk,
  input  logic                              rst,
  input  fbufStrobe_t                       strobe,
  input  logic [$clog2(QUEUE_DEPTH)-1:0]    headPtr,
  input  logic [$clog2(QUEUE_DEPTH)-1:0]    tailPtr,
  input  logic [$clog2(FETCH_WIDTH+1)-1:0]  wrSkip,
  input  logic [$clog2(FETCH_WIDTH+1)-1:0]  wrCnt,
  input  logic [$clog2(DEQ_WIDTH+1)-1:0]    outCnt,
  input  fbufSlot_t [FETCH_WIDTH-1:0]       packedIn,
  output fbufSlot_t [DEQ_WIDTH-1:0]         deqSlot,
  output logic [DEQ_WIDTH-1:0]              deqValid
);
  localparam int PTR_W = $clog2(QUEUE_DEPTH);
  localparam int SRC_W = (FETCH_WIDTH > 1) ? $clog2(FETCH_WIDTH) : 1;

  fbufSlot_t        store [QUEUE_DEPTH];
  logic [QUEUE_DEPTH-1:0] entWe;
  logic [SRC_W-1:0] entSrc [QUEUE_DEPTH];

  // Per-entry write decode: offset from tail selects a packed position
  always_comb begin
    for (int e = 0; e < QUEUE_DEPTH; e++) begin
      int off;
      int src;
      off = (e - int'(tailPtr) + QUEUE_DEPTH) % QUEUE_DEPTH;
      src = off + int'(wrSkip);
      entWe[e]  = strobe.writeEn && (off < int'(wrCnt)) && (src < FETCH_WIDTH);
      entSrc[e] = SRC_W'(src);
    end
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < QUEUE_DEPTH; e++) begin
      if (entWe[e]) store[e] <= packedIn[entSrc[e]];
    end
  end

  // Read lanes from head, or straight from the arriving packet when empty
  always_comb begin
    for (int k = 0; k < DEQ_WIDTH; k++) begin
      logic [PTR_W-1:0] rdIdx;
      rdIdx = PTR_W'((int'(headPtr) + k) % QUEUE_DEPTH);
      deqSlot[k]  = strobe.bypassEn ? packedIn[k] : store[rdIdx];
      deqValid[k] = (k < int'(outCnt));
    end
  end

  // R5
  thermometer_chk: assert property (@(posedge clk) disable iff (rst)
    (deqValid & (deqValid + 1'b1)) == '0);

  // R10
  empty_packet_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.bypassEn && (wrCnt == '0) && (wrSkip == '0)) |-> (deqValid == '0));
endmodule

// File: rtl/instPackQueue.sv
module instPackQueue
  import fbufPkg::*;
#(
  parameter int FETCH_WIDTH = 4,
  parameter int QUEUE_DEPTH = 16,
  parameter int DEQ_WIDTH   = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          flush,
  input  logic                          enqValid,
  output logic                          enqReady,
  input  logic [FETCH_WIDTH-1:0]        enqMask,
  input  logic [INST_W*FETCH_WIDTH-1:0] enqInst,
  input  logic [PC_W*FETCH_WIDTH-1:0]   enqPc,
  input  logic [FETCH_WIDTH-1:0]        enqRvc,
  input  logic                          deqReady,
  output logic [DEQ_WIDTH-1:0]          deqValid,
  output logic [INST_W*DEQ_WIDTH-1:0]   deqInst,
  output logic [PC_W*DEQ_WIDTH-1:0]     deqPc,
  output logic [DEQ_WIDTH-1:0]          deqRvc
);
  localparam int PTR_W  = $clog2(QUEUE_DEPTH);
  localparam int FCNT_W = $clog2(FETCH_WIDTH + 1);
  localparam int DCNT_W = $clog2(DEQ_WIDTH + 1);

  fbufSlot_t [FETCH_WIDTH-1:0] slotIn, packedSlots;
  fbufSlot_t [DEQ_WIDTH-1:0]   deqSlot;
  logic [FCNT_W-1:0]           enqCnt, wrSkip, wrCnt;
  logic [DCNT_W-1:0]           outCnt;
  logic [PTR_W-1:0]            headPtr, tailPtr;
  fbufStrobe_t                 strobe;

  for (genvar i = 0; i < FETCH_WIDTH; i++) begin : g_slotIn
    assign slotIn[i].inst    = enqInst[i*INST_W +: INST_W];
    assign slotIn[i].pc      = enqPc[i*PC_W +: PC_W];
    assign slotIn[i].fromRvc = enqRvc[i];
  end

  fbufCompact #(.FETCH_WIDTH(FETCH_WIDTH)) i_compact (
    .slotMask (enqMask),
    .slotIn   (slotIn),
    .packedOut(packedSlots),
    .packedCnt(enqCnt)
  );

  fbufCtrl #(
    .FETCH_WIDTH(FETCH_WIDTH), .QUEUE_DEPTH(QUEUE_DEPTH), .DEQ_WIDTH(DEQ_WIDTH)
  ) i_ctrl (
    .clk     (clk),
    .rst     (rst),
    .flush   (flush),
    .enqValid(enqValid),
    .enqCnt  (enqCnt),
    .deqReady(deqReady),
    .enqReady(enqReady),
    .headPtr (headPtr),
    .tailPtr (tailPtr),
    .wrSkip  (wrSkip),
    .wrCnt   (wrCnt),
    .outCnt  (outCnt),
    .strobe  (strobe)
  );

  fbufData #(
    .FETCH_WIDTH(FETCH_WIDTH), .QUEUE_DEPTH(QUEUE_DEPTH), .DEQ_WIDTH(DEQ_WIDTH)
  ) i_data (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .headPtr (headPtr),
    .tailPtr (tailPtr),
    .wrSkip  (wrSkip),
    .wrCnt   (wrCnt),
    .outCnt  (outCnt),
    .packedIn(packedSlots),
    .deqSlot (deqSlot),
    .deqValid(deqValid)
  );

  for (genvar k = 0; k < DEQ_WIDTH; k++) begin : g_deqOut
    assign deqInst[k*INST_W +: INST_W] = deqSlot[k].inst;
    assign deqPc[k*PC_W +: PC_W]       = deqSlot[k].pc;
    assign deqRvc[k]                   = deqSlot[k].fromRvc;
  end
endmodule

// File: tb/test_instPackQueue.sv
`timescale 1ns/1ps
module test_instPackQueue;
  localparam int FW = 4;
  localparam int DEPTH = 16;
  localparam int DW = 2;

  logic clk = 0;
  logic rst = 1;
  logic flush = 0;
  logic enqValid = 0;
  logic enqReady;
  logic [FW-1:0] enqMask = '0;
  logic [32*FW-1:0] enqInst = '0;
  logic [32*FW-1:0] enqPc = '0;
  logic [FW-1:0] enqRvc = '0;
  logic deqReady = 0;
  logic [DW-1:0] deqValid;
  logic [32*DW-1:0] deqInst;
  logic [32*DW-1:0] deqPc;
  logic [DW-1:0] deqRvc;

  always #4 clk = ~clk;

  instPackQueue #(.FETCH_WIDTH(FW), .QUEUE_DEPTH(DEPTH), .DEQ_WIDTH(DW)) i_instPackQueue (
    .clk(clk), .rst(rst), .flush(flush), .enqValid(enqValid), .enqReady(enqReady),
    .enqMask(enqMask), .enqInst(enqInst), .enqPc(enqPc), .enqRvc(enqRvc),
    .deqReady(deqReady), .deqValid(deqValid), .deqInst(deqInst), .deqPc(deqPc),
    .deqRvc(deqRvc)
  );

  typedef struct {
    logic [31:0] inst;
    logic [31:0] pc;
    logic        rvc;
  } ent_t;

  ent_t model[$];
  int checks = 0;
  int fails = 0;
  bit done = 0;

  task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // One cycle: drive, compare against the reference, then advance the reference
  task automatic step(input logic ev, input logic [FW-1:0] m, input logic dr, input logic fl, input string tag);
    ent_t pk[$];
    ent_t outs[$];
    bit expReady, fire, wasEmpty;
    int skip, npop;
    @(negedge clk);
    enqValid = ev;
    enqMask  = m;
    deqReady = dr;
    flush    = fl;
    for (int i = 0; i < FW; i++) begin
      enqInst[i*32 +: 32] = $urandom;
      enqPc[i*32 +: 32]   = $urandom;
      enqRvc[i]           = 1'($urandom % 2);
    end
    #1;
    for (int i = 0; i < FW; i++) begin
      if (m[i]) pk.push_back('{enqInst[i*32 +: 32], enqPc[i*32 +: 32], enqRvc[i]});
    end
    expReady = (DEPTH - model.size()) >= FW;
    fire = ev && expReady && !fl;
    wasEmpty = (model.size() == 0);
    if (!fl) begin
      if (!wasEmpty) begin
        for (int k = 0; k < DW && k < model.size(); k++) outs.push_back(model[k]);
      end else if (fire) begin
        for (int k = 0; k < DW && k < pk.size(); k++) outs.push_back(pk[k]);
      end
    end
    check(enqReady == expReady, {tag, " enqReady (R2)"}, 64'(enqReady), 64'(expReady));
    check(deqValid == DW'((1 << outs.size()) - 1), {tag, " deqValid (R5)"},
          64'(deqValid), 64'((1 << outs.size()) - 1));
    for (int k = 0; k < outs.size(); k++) begin
      check(deqInst[k*32 +: 32] == outs[k].inst, {tag, " inst order (R3/R4)"},
            64'(deqInst[k*32 +: 32]), 64'(outs[k].inst));
      check(deqPc[k*32 +: 32] == outs[k].pc, {tag, " pc (R4)"},
            64'(deqPc[k*32 +: 32]), 64'(outs[k].pc));
      check(deqRvc[k] == outs[k].rvc, {tag, " rvc flag (R4)"},
            64'(deqRvc[k]), 64'(outs[k].rvc));
    end
    @(posedge clk);
    if (fl) begin
      model.delete();
    end else begin
      if (dr && !wasEmpty) begin
        npop = outs.size();
        for (int k = 0; k < npop; k++) void'(model.pop_front());
      end
      if (fire) begin
        skip = (wasEmpty && dr) ? outs.size() : 0;
        for (int k = skip; k < pk.size(); k++) model.push_back(pk[k]);
      end
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    check(enqReady == 1'b1, "R1 enqReady in reset", 64'(enqReady), 64'd1);
    check(deqValid == '0, "R1 deqValid in reset", 64'(deqValid), 64'd0);
    rst = 0;
    #1;
    check(enqReady == 1'b1, "R1 enqReady after reset", 64'(enqReady), 64'd1);
    check(deqValid == '0, "R1 deqValid after reset", 64'(deqValid), 64'd0);

    // R7 same-cycle delivery when empty
    step(1, 4'b1011, 1, 0, "R7 bypass");
    step(0, 4'b0000, 1, 0, "R7 bypass remainder");
    step(1, 4'b0100, 1, 0, "R7 single");
    step(1, 4'b0100, 0, 0, "R7 shown not taken");
    step(0, 4'b0000, 1, 0, "R7 stored after bypass");

    // R3 sparse masks, then fill to the point of refusal
    step(1, 4'b1010, 0, 0, "R3 sparse");
    step(1, 4'b0110, 0, 0, "R3 sparse");
    step(1, 4'b1001, 0, 0, "R3 sparse");
    for (int n = 0; n < 4; n++) step(1, 4'b1111, 0, 0, "R8 fill");
    for (int n = 0; n < 3; n++) step(1, 4'b1111, 0, 0, "R8 refused");

    // R6 hold then drain
    for (int n = 0; n < 3; n++) step(0, 4'b0000, 0, 0, "R6 stall");
    for (int n = 0; n < 12; n++) step(0, 4'b0000, 1, 0, "R6 drain");

    // R9 flush with held contents and with an arriving packet
    step(1, 4'b1111, 0, 0, "R9 prefill");
    step(1, 4'b0111, 0, 0, "R9 prefill");
    step(1, 4'b1111, 1, 1, "R9 flush held");
    step(0, 4'b0000, 1, 0, "R9 after flush");
    step(1, 4'b1111, 1, 1, "R9 flush bypass");
    step(0, 4'b0000, 1, 0, "R9 after flush bypass");

    // R10 all-zero masks
    step(1, 4'b0000, 1, 0, "R10 empty mask");
    step(0, 4'b0000, 1, 0, "R10 after empty mask");
    step(1, 4'b0011, 0, 0, "R10 prefill");
    step(1, 4'b0000, 0, 0, "R10 empty mask held");
    step(0, 4'b0000, 1, 0, "R10 drain");
    step(0, 4'b0000, 1, 0, "R10 drain");

    // R4 random traffic
    for (int n = 0; n < 4000; n++) begin
      step(($urandom % 4) != 0, FW'($urandom), ($urandom % 3) != 0,
           ($urandom % 64) == 0, "R4 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule